// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block decides when the SDRAM sequencer should run a refresh. A 10-bit timer counts clock cycles up to a programmed period. Each time the period elapses, the block marks a refresh as owed. The request goes out to the sequencer only while no memory access is in flight. An access that is already running is never cut short: the request waits until the busy indication drops.

The request stays up until the sequencer accepts it with an acknowledge. The timer restarts at every expiry, whether or not the previous refresh has been served, so refresh spacing does not drift when a request has to wait. If a period elapses while an earlier refresh is still owed, a sticky flag records the lost refresh until it is cleared. A period of zero turns the timer off. A new period is picked up only when the timer restarts, so the interval in progress always runs to its end.

Top module: `refresh_sched`

## Requirements
- R1: After reset `req_o` and `miss_o` are 0, no refresh is owed and the timer is idle.
- R2: With a nonzero period N picked up at a timer restart, a refresh becomes owed every N cycles. When the timer loads N out of the idle state on clock edge E, the first request appears after edge E+N. Later requests follow at N-cycle spacing.
- R3: While `busy_i` is 1, `req_o` is 0 even if a refresh is owed. An owed refresh drives `req_o` to 1 in the same cycle that `busy_i` returns to 0.
- R4: Once raised, `req_o` stays at 1 until a clock edge that samples `ack_i`=1 together with `req_o`=1. That edge clears the request. An `ack_i` seen while `req_o` is 0 is ignored, including while a refresh is owed but held back by `busy_i`.
- R5: The timer restarts from zero on every expiry, whatever the state of the request, so the spacing of expiries does not depend on when acknowledges arrive.
- R6: If the timer expires while a refresh is still owed and is not acknowledged on that same edge, `miss_o` becomes 1 after that edge. An acknowledge on the expiry edge prevents the flag, and the new refresh stays owed.
- R7: `miss_o` holds until `clr_miss_i` is sampled at 1. If a miss occurs on the same edge as a clear, the flag stays at 1.
- R8: While the loaded period is zero, no refresh is ever requested.
- R9: A change of `interval_i` in the middle of an interval has no effect until the next restart. The restart loads the new value, and so does every cycle in which the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_i | input | 10 | Refresh period in cycles; 0 disables the timer |
| busy_i | input | 1 | A memory access is in flight; holds the request back |
| ack_i | input | 1 | Sequencer accepts the refresh request |
| clr_miss_i | input | 1 | Clears the missed-refresh flag |
| req_o | output | 1 | Refresh request toward the sequencer |
| miss_o | output | 1 | Sticky flag: a period elapsed while a refresh was still owed |

## Verification
The assertions check these properties on every cycle: no request while busy, a request is held until acknowledged, the timer resets to zero at each expiry and never runs past its period, the period is stable between restarts, the missed flag only rises at an expiry and is sticky, and a zero period produces no expiries. The bench scenarios are needed for the rest. These are the exact cycle on which each request rises, the spacing after a mid-interval period change, and the release of a deferred request at the moment busy drops. They also cover the set-over-clear priority of the missed flag and the edge periods of 1 and 1023 cycles.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // Expiry: the last count value of a nonzero period.
  function automatic logic period_done(input int unsigned cnt, input int unsigned lim);
    return (lim != 0) && ((cnt + 1) == lim);
  endfunction

  // Owed-refresh flag for the next cycle.
  function automatic logic owed_next(input logic expire, input logic owed, input logic taken);
    return expire | (owed & ~taken);
  endfunction

  // Missed-refresh flag for the next cycle: a new miss wins over a clear.
  function automatic logic lost_next(input logic expire, input logic owed, input logic taken,
                                     input logic lost, input logic clr);
    return (expire & owed & ~taken) | (lost & ~clr);
  endfunction

endpackage

// File: rtl/rs_interval_timer.sv
module rs_interval_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval_i,
  output logic             expire_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] lim_o
);
  import refresh_sched_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;
  logic             idle;

  assign idle     = (lim_q == '0);
  assign expire_o = period_done(32'(cnt_q), 32'(lim_q));

  // The period is sampled only when idle or at a restart.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (idle || expire_o) begin
      cnt_q <= '0;
      lim_q <= interval_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign lim_o = lim_q;
endmodule

// File: rtl/rs_req_tracker.sv
module rs_req_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic expire_i,
  input  logic busy_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic req_o,
  output logic lost_o,
  output logic taken_o
);
  import refresh_sched_pkg::*;

  logic owed_q;
  logic lost_q;

  // Deferral: an owed refresh is only offered while no access runs.
  assign req_o   = owed_q & ~busy_i;
  assign taken_o = ack_i & req_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      owed_q <= owed_next(expire_i, owed_q, taken_o);
      lost_q <= lost_next(expire_i, owed_q, taken_o, lost_q, clr_i);
    end
  end

  assign lost_o = lost_q;
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             busy_i,
  input  logic             ack_i,
  input  logic             clr_miss_i,
  output logic             req_o,
  output logic             miss_o
);
  // Named internal events for the bound checker.
  logic             tick_w;
  logic             take_w;
  logic [CNT_W-1:0] cnt_w;
  logic [CNT_W-1:0] lim_w;

  rs_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .interval_i (interval_i),
    .expire_o   (tick_w),
    .cnt_o      (cnt_w),
    .lim_o      (lim_w)
  );

  rs_req_tracker u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire_i (tick_w),
    .busy_i   (busy_i),
    .ack_i    (ack_i),
    .clr_i    (clr_miss_i),
    .req_o    (req_o),
    .lost_o   (miss_o),
    .taken_o  (take_w)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_i,
  input logic             ack_i,
  input logic             clr_miss_i,
  input logic             req_o,
  input logic             miss_o,
  input logic             tick_w,
  input logic             take_w,
  input logic [CNT_W-1:0] cnt_w,
  input logic [CNT_W-1:0] lim_w
);
  assert_defer_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> !req_o);

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o || busy_i));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_w && !tick_w) |=> !req_o);

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_w |=> (cnt_w == '0));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_w != '0) |-> (cnt_w < lim_w));

  assert_miss_at_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_o ##1 miss_o) |-> $past(tick_w));

  assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_o && !clr_miss_i) |=> miss_o);

  assert_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_w == '0) |-> !tick_w);

  assert_period_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_w && lim_w != '0) |=> $stable(lim_w));
endmodule

bind refresh_sched refresh_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy_i     (busy_i),
  .ack_i      (ack_i),
  .clr_miss_i (clr_miss_i),
  .req_o      (req_o),
  .miss_o     (miss_o),
  .tick_w     (tick_w),
  .take_w     (take_w),
  .cnt_w      (cnt_w),
  .lim_w      (lim_w)
);

// File: tb/tb_refresh_sched.sv
`timescale 1ns/1ps
module tb_refresh_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] interval_i = '0;
  logic       busy_i = 1'b0;
  logic       man_ack = 1'b0;
  logic       auto_ack = 1'b0;
  logic       auto_q = 1'b0;
  logic       ack_i;
  logic       clr_miss_i = 1'b0;
  logic       req_o;
  logic       miss_o;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  int base = 0;
  int exp_q[$];
  logic prev_req = 1'b0;
  int mon_e;

  assign ack_i = man_ack | auto_q;

  refresh_sched dut (
    .clk(clk), .rst_n(rst_n), .interval_i(interval_i), .busy_i(busy_i),
    .ack_i(ack_i), .clr_miss_i(clr_miss_i), .req_o(req_o), .miss_o(miss_o)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic wait_to(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; interval_i = '0; busy_i = 1'b0; man_ack = 1'b0;
    auto_ack = 1'b0; clr_miss_i = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic start(input int n, input logic aa);
    auto_ack = aa;
    base = cyc;
    interval_i = 10'(n);
  endtask

  // Monitor: compares every request rise with the scoreboard queue.
  initial forever begin
    @(negedge clk); #1;
    if (!rst_n) begin
      prev_req = 1'b0;
    end else begin
      if (req_o && !prev_req) begin
        if (exp_q.size() == 0) begin
          total++; bad++;
          $display("FAIL R2: request rise at cycle %0d, expected none", cyc);
        end else begin
          mon_e = exp_q.pop_front();
          chk("R2 rise cycle", cyc, mon_e);
        end
      end
      prev_req = req_o;
    end
  end

  // Automatic acknowledger.
  initial forever begin
    @(negedge clk); #1;
    auto_q = auto_ack && rst_n && req_o;
  end

  initial begin
    repeat (60000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state, R8 zero period idle
    do_reset();
    chk("R1 req after reset", int'(req_o), 0);
    chk("R1 miss after reset", int'(miss_o), 0);
    start(0, 1'b1);
    wait_to(base + 20);
    chk("R8 no request at zero period", int'(req_o), 0);

    // R2 periodic requests, R4 ack ignored while no request
    do_reset();
    start(5, 1'b1);
    exp_q.push_back(base + 6); exp_q.push_back(base + 11); exp_q.push_back(base + 16);
    wait_to(base + 2); man_ack = 1'b1;
    wait_to(base + 3); man_ack = 1'b0;
    wait_to(base + 18);
    chk("R2 all rises seen", exp_q.size(), 0);
    chk("R4 early ack harmless, no miss", int'(miss_o), 0);

    // R3 deferral while busy, R4 ack while held back is ignored
    do_reset();
    busy_i = 1'b1;
    start(10, 1'b1);
    exp_q.push_back(base + 14); exp_q.push_back(base + 21);
    wait_to(base + 12); man_ack = 1'b1;
    chk("R3 held back while busy", int'(req_o), 0);
    wait_to(base + 13); man_ack = 1'b0;
    wait_to(base + 14); busy_i = 1'b0;
    wait_to(base + 22);
    chk("R3 deferred rises seen", exp_q.size(), 0);
    chk("R4 ack while busy ignored, no miss", int'(miss_o), 0);

    // R4 hold, R5 restart, R6 miss, R7 clear and set-wins
    do_reset();
    start(6, 1'b0);
    exp_q.push_back(base + 7); exp_q.push_back(base + 19);
    wait_to(base + 9);
    chk("R4 request held without ack", int'(req_o), 1);
    wait_to(base + 12);
    chk("R6 no miss before expiry", int'(miss_o), 0);
    wait_to(base + 13);
    chk("R6 miss after expiry while owed", int'(miss_o), 1);
    wait_to(base + 14); clr_miss_i = 1'b1; man_ack = 1'b1;
    wait_to(base + 15); clr_miss_i = 1'b0; man_ack = 1'b0;
    chk("R7 miss cleared", int'(miss_o), 0);
    chk("R4 ack clears request", int'(req_o), 0);
    wait_to(base + 24); clr_miss_i = 1'b1;
    wait_to(base + 25); clr_miss_i = 1'b0;
    chk("R7 new miss wins over clear", int'(miss_o), 1);
    wait_to(base + 26);
    chk("R5 spacing kept despite late ack", exp_q.size(), 0);

    // R9 period change applies at the next restart
    do_reset();
    start(8, 1'b1);
    exp_q.push_back(base + 9); exp_q.push_back(base + 12); exp_q.push_back(base + 15);
    wait_to(base + 3); interval_i = 10'd3;
    wait_to(base + 17);
    chk("R9 new period after restart", exp_q.size(), 0);

    // R8 switching to zero stops requests after the restart
    do_reset();
    start(4, 1'b1);
    exp_q.push_back(base + 5); exp_q.push_back(base + 9);
    wait_to(base + 6); interval_i = 10'd0;
    wait_to(base + 40);
    chk("R8 requests stopped", exp_q.size(), 0);
    chk("R8 request low when disabled", int'(req_o), 0);

    // R6 boundary: period 1 with ack on each expiry edge gives no miss
    do_reset();
    start(1, 1'b1);
    exp_q.push_back(base + 2);
    wait_to(base + 25);
    chk("R6 ack on expiry edge prevents miss", int'(miss_o), 0);
    chk("R6 refresh still owed", int'(req_o), 1);
    chk("R6 single continuous request", exp_q.size(), 0);

    // R2 boundary: maximum period
    do_reset();
    start(1023, 1'b1);
    exp_q.push_back(base + 1024); exp_q.push_back(base + 2047);
    wait_to(base + 2050);
    chk("R2 maximum period", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule